// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block puts a synchronous burst-SRAM command interface in front of a small internal memory. On each rising clock edge it sorts the control inputs into one of five cycle kinds: idle, deselect, burst start, burst step or burst hold. It then performs the read or the lane-masked write that the cycle calls for.

Two address strobes can start a burst. The processor-side strobe always starts a read. The controller-side strobe can start either a read or a write. The first chip enable gates only the processor-side strobe. The other two chip enables matter only when a strobe is sampled.

Read data leaves through a path chosen by a mode input. One choice is a registered path that adds one clock of latency; the other bypasses that register. An asynchronous output enable can only suppress drive. It never creates drive. A parameter selects whether burst steps follow linear or interleaved order inside the aligned four-word block.

Top module: `sburst_ctrl`

## Requirements
- R1: With the processor-side strobe low, the first chip enable low, and the second and third enables true (second high, third low), the cycle starts a read burst at `addr`. This holds even when the write controls request a write.
- R2: A write burst starts only when all of these hold: the controller-side strobe is low, the processor-side strobe is high or masked, all three chip enables are true, and the write condition holds.
- R3: While the first chip enable is high, the processor-side strobe has no effect. A controller-side strobe in such a cycle is a deselect, and the next data slot is not driven.
- R4: The second and third chip enables matter only on strobe cycles. If either is false during a strobe, the cycle is a deselect. Outside strobe cycles they have no effect on the burst.
- R5: With both strobes high and `adv_n` low during an active burst, the access moves to the next word of the aligned four-word block. In linear order that is the low two bits plus one, wrapping from 3 to 0.
- R6: With both strobes high and `adv_n` high during an active burst, the access repeats the current address.
- R7: With parameter INTERLEAVE=1, burst word k uses the low two address bits equal to the start bits XOR k.
- R8: With `gw_n` low, all byte lanes are written; lane i occupies bits [9i+8:9i]. Otherwise, `bwe_n` low writes only the lanes whose `lane_we_n` bit is low. If neither condition holds, the cycle is a read.
- R9: A read drives every lane, whatever the lane enables say. A write cycle leaves its data slot undriven.
- R10: With `pipe_mode` low, the read data for a command sampled at edge N is driven after edge N. With `pipe_mode` high, it is driven after edge N+1.
- R11: `oe_n` high forces `rdrive` low and `rdata` to zero at once, without waiting for a clock edge.
- R12: A read with `oe_n` high still advances the burst address, exactly as a driven read does.
- R13: A single deselect cycle is enough to end output drive in its own data slot. That allows a write to follow a read after one deselect.
- R14: Reset clears every memory word to zero and leaves the outputs undriven (`rdrive`=0, `rdata`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | First chip enable, active low, masks processor-side strobe |
| ce2 | input | 1 | Second chip enable, active high, sampled with strobes |
| ce3_n | input | 1 | Third chip enable, active low, sampled with strobes |
| strb_p_n | input | 1 | Processor-side address strobe, active low |
| strb_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | External word address |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 = registered read path, 0 = flow-through |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdrive | output | 1 | High when read data is being driven |

## Verification
Most internal faults in this block show up at the ports within one or two clocks. A wrong cycle classification shows as a missing or spurious `rdrive` in the very next data slot, or as data read back from the wrong word. A burst counter that steps or wraps incorrectly shows as wrong data on the second to fifth beat of a read burst. A write-mask fault appears only when the word is read back later. A fault in the pipeline register shows as data arriving one slot early or late when `pipe_mode` is high.

// File: rtl/sb_pkg.sv
package sb_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE  = 3'd0,
      CYC_DESEL = 3'd1,
      CYC_BEGIN = 3'd2,
      CYC_CONT  = 3'd3,
      CYC_SUSP  = 3'd4
   } cyc_e;
endpackage

// File: rtl/sb_cycle_dec.sv
module sb_cycle_dec
   import sb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic strb_p_n,
   input  logic strb_c_n,
   input  logic adv_n,
   input  logic ce1_n,
   input  logic ce2,
   input  logic ce3_n,
   input  logic wr_req,
   input  logic burst_act,
   output cyc_e cyc,
   output logic is_wr
);
   logic sel_ok;

   always_comb begin
      sel_ok = ce2 && !ce3_n;
      cyc    = CYC_IDLE;
      is_wr  = 1'b0;
      if (!strb_p_n && !ce1_n) begin
         // processor strobe: read start regardless of write controls
         cyc = sel_ok ? CYC_BEGIN : CYC_DESEL;
      end else if (!strb_c_n) begin
         if (!ce1_n && sel_ok) begin
            cyc   = CYC_BEGIN;
            is_wr = wr_req;
         end else begin
            cyc = CYC_DESEL;
         end
      end else if (burst_act) begin
         cyc   = adv_n ? CYC_SUSP : CYC_CONT;
         is_wr = wr_req;
      end
   end

   // R2
   wr_begin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_BEGIN && is_wr) |-> (!strb_c_n && !ce1_n));

   // R4
   strobe_only_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_p_n && strb_c_n) |-> (cyc != CYC_DESEL));
endmodule

// File: rtl/sb_burst_cnt.sv
module sb_burst_cnt
   import sb_pkg::*;
#(
   parameter int AW         = 8,
   parameter bit INTERLEAVE = 1'b0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  cyc_e          cyc,
   input  logic [AW-1:0] ext_addr,
   output logic [AW-1:0] cur_addr,
   output logic          burst_act
);
   localparam int BW = 2;

   logic [AW-1:0] base_q;
   logic [BW-1:0] beat_q;
   logic [BW-1:0] beat_use;
   logic [BW-1:0] low_bits;
   logic          act_q;

   if (AW < 3) begin : g_aw_bad
      $error("sb_burst_cnt: AW must be at least 3");
   end

   always_comb begin
      beat_use = (cyc == CYC_CONT) ? beat_q + 2'd1 : beat_q;
   end

   if (INTERLEAVE) begin : g_ilv
      always_comb low_bits = base_q[BW-1:0] ^ beat_use;
   end else begin : g_lin
      always_comb low_bits = base_q[BW-1:0] + beat_use;
   end

   always_comb begin
      if (cyc == CYC_BEGIN) cur_addr = ext_addr;
      else                  cur_addr = {base_q[AW-1:BW], low_bits};
   end

   assign burst_act = act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
         act_q  <= 1'b0;
      end else begin
         case (cyc)
            CYC_BEGIN: begin
               base_q <= ext_addr;
               beat_q <= '0;
               act_q  <= 1'b1;
            end
            CYC_CONT:  beat_q <= beat_q + 2'd1;
            CYC_DESEL: act_q  <= 1'b0;
            default: ;
         endcase
      end
   end

   // R6
   susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_SUSP) |-> (cur_addr == $past(cur_addr)));

   // R5
   cont_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_CONT) |-> (cur_addr[AW-1:BW] == $past(cur_addr[AW-1:BW])
                             && cur_addr != $past(cur_addr)));
endmodule

// File: rtl/sb_lane_mem.sv
module sb_lane_mem #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   parameter int AW     = 8
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_en,
   input  logic [AW-1:0]           waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [AW-1:0]           raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] arr [DEPTH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
         end else if (we && lane_en[g]) begin
            arr[waddr] <= wdata[g*LANE_W +: LANE_W];
         end
      end

      assign rdata[g*LANE_W +: LANE_W] = arr[raddr];
   end
endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
   import sb_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   parameter int DEPTH      = 256,
   parameter bit INTERLEAVE = 1'b0,
   localparam int DW        = LANES * LANE_W,
   localparam int AW        = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce1_n,
   input  logic             ce2,
   input  logic             ce3_n,
   input  logic             strb_p_n,
   input  logic             strb_c_n,
   input  logic             adv_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] lane_we_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic             oe_n,
   input  logic             pipe_mode,
   output logic [DW-1:0]    rdata,
   output logic             rdrive
);
   if (LANES < 1 || LANE_W < 1) begin : g_lane_bad
      $error("sburst_ctrl: LANES and LANE_W must be positive");
   end
   if (DEPTH < 8 || (1 << AW) != DEPTH) begin : g_depth_bad
      $error("sburst_ctrl: DEPTH must be a power of two of at least 8");
   end

   cyc_e             cyc;
   logic             is_wr;
   logic             wr_req;
   logic [LANES-1:0] lane_req;
   logic [LANES-1:0] lane_en;
   logic [AW-1:0]    cur_addr;
   logic             burst_act;
   logic             access;
   logic             mem_we;
   logic             rd_cyc;
   logic [AW-1:0]    raddr_q;
   logic             slot1_q;
   logic             slot2_q;
   logic [DW-1:0]    flow_data;
   logic [DW-1:0]    pdata_q;

   always_comb begin
      lane_req = ~lane_we_n;
      wr_req   = !gw_n || (!bwe_n && (|lane_req));
      lane_en  = !gw_n ? {LANES{1'b1}} : lane_req;
      access   = (cyc == CYC_BEGIN) || (cyc == CYC_CONT) || (cyc == CYC_SUSP);
      mem_we   = access && is_wr;
      rd_cyc   = access && !is_wr;
   end

   sb_cycle_dec u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .strb_p_n  (strb_p_n),
      .strb_c_n  (strb_c_n),
      .adv_n     (adv_n),
      .ce1_n     (ce1_n),
      .ce2       (ce2),
      .ce3_n     (ce3_n),
      .wr_req    (wr_req),
      .burst_act (burst_act),
      .cyc       (cyc),
      .is_wr     (is_wr)
   );

   sb_burst_cnt #(.AW(AW), .INTERLEAVE(INTERLEAVE)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc       (cyc),
      .ext_addr  (addr),
      .cur_addr  (cur_addr),
      .burst_act (burst_act)
   );

   sb_lane_mem #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (mem_we),
      .lane_en (lane_en),
      .waddr   (cur_addr),
      .wdata   (wdata),
      .raddr   (raddr_q),
      .rdata   (flow_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raddr_q <= '0;
         slot1_q <= 1'b0;
         slot2_q <= 1'b0;
         pdata_q <= '0;
      end else begin
         if (rd_cyc) raddr_q <= cur_addr;
         slot1_q <= rd_cyc;
         slot2_q <= slot1_q;
         if (slot1_q) pdata_q <= flow_data;
      end
   end

   always_comb begin
      rdrive = !oe_n && (pipe_mode ? slot2_q : slot1_q);
      rdata  = rdrive ? (pipe_mode ? pdata_q : flow_data) : '0;
   end

   // R1
   rd_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_p_n && !ce1_n && ce2 && !ce3_n) |=> slot1_q);

   // R3
   ce1_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_c_n && ce1_n) |=> !slot1_q);

   // R13
   desel_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_DESEL) |=> !slot1_q);

   // R9
   wr_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !slot1_q);

   // R10
   pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && slot1_q) |=> (rdrive || oe_n || !pipe_mode));
endmodule

// File: tb/sim_sburst_ctrl.sv
`timescale 1ns/1ps
module sim_sburst_ctrl;
   typedef struct packed {
      logic        p_n, c_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n;
      logic [3:0]  lw_n;
      logic        oe_n;
      logic [7:0]  a;
      logic [35:0] wd;
      logic        edrv;
      logic [35:0] ed;
      logic [7:0]  rq;
   } vec_t;

   function automatic vec_t mk(logic p_n, logic c_n, logic adv_n, logic ce1_n,
                               logic ce2, logic ce3_n, logic gw_n, logic bwe_n,
                               logic [3:0] lw_n, logic oe_n, logic [7:0] a,
                               logic [35:0] wd, logic edrv, logic [35:0] ed,
                               logic [7:0] rq);
      vec_t v;
      v = '{p_n, c_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, lw_n, oe_n, a, wd, edrv, ed, rq};
      return v;
   endfunction

   localparam logic [35:0] A1 = 36'h123456789;
   localparam logic [35:0] A2 = 36'h0AAAA5555;
   localparam logic [35:0] A3 = 36'hF0F0F0F0F;
   localparam logic [35:0] A4 = 36'h13579BDF0;
   localparam logic [35:0] MRG = 36'h0AFFE55FF;
   localparam logic [35:0] PV = 36'h5A5A5A5A5;
   localparam int NV = 17;

   // Flow-through mode; expectation is for the slot that follows the vector.
   localparam vec_t TBL [NV] = '{
      mk(1,0,1,0,1,0,0,1,4'hF,0,8'h10,A1,0,0,2),          // R2 R8 R9 write start, all lanes
      mk(1,1,0,0,1,0,0,1,4'hF,0,8'h00,A2,0,0,5),          // R5 write step 0x11
      mk(1,1,0,0,1,0,0,1,4'hF,0,8'h00,A3,0,0,5),          // R5 0x12
      mk(1,1,0,0,1,0,0,1,4'hF,0,8'h00,A4,0,0,5),          // R5 0x13
      mk(1,0,1,1,1,0,1,1,4'hF,0,8'h00,0,0,0,3),           // R3 ce1 high + ctrl strobe
      mk(0,1,1,0,1,0,0,1,4'hF,0,8'h12,0,1,A3,1),          // R1 read despite gw_n low
      mk(1,1,0,0,1,0,1,1,4'hF,0,8'h00,0,1,A4,5),          // R5 0x13
      mk(1,1,0,0,1,0,1,1,4'hF,0,8'h00,0,1,A1,5),          // R5 wrap to 0x10
      mk(1,1,1,0,1,0,1,1,4'hF,0,8'h00,0,1,A1,6),          // R6 hold
      mk(0,1,1,0,0,0,1,1,4'hF,0,8'h12,0,0,0,4),           // R4 ce2 low on strobe
      mk(1,0,1,0,1,0,1,0,4'b1010,0,8'h11,36'hFFFFFFFFF,0,0,8), // R8 lanes 0,2
      mk(1,0,1,0,1,0,1,0,4'hF,0,8'h11,0,1,MRG,8),         // R8 R9 read merged word
      mk(1,0,1,0,1,0,1,1,4'h0,0,8'h10,0,1,A1,8),          // R8 lanes ignored w/o bwe
      mk(1,1,0,0,1,0,1,1,4'hF,1,8'h00,0,0,0,11),          // R11 R12 dummy read 0x11
      mk(1,1,0,0,1,0,1,1,4'hF,0,8'h00,0,1,A3,12),         // R12 moved to 0x12
      mk(1,1,0,0,0,1,1,1,4'hF,0,8'h00,0,1,A4,4),          // R4 enables ignored w/o strobe
      mk(1,0,1,0,1,0,1,1,4'hF,0,8'h40,0,1,0,14)           // R14 untouched word is zero
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce1_n, ce2, ce3_n, strb_p_n, strb_c_n, adv_n, gw_n, bwe_n, oe_n, pipe_mode;
   logic [3:0]  lane_we_n;
   logic [7:0]  addr;
   logic [35:0] wdata;
   logic [35:0] rdata, rdata1;
   logic        rdrive, rdrive1;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   sburst_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .gw_n(gw_n),
      .bwe_n(bwe_n), .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata),
      .oe_n(oe_n), .pipe_mode(pipe_mode), .rdata(rdata), .rdrive(rdrive));

   sburst_ctrl #(.INTERLEAVE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .gw_n(gw_n),
      .bwe_n(bwe_n), .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata),
      .oe_n(oe_n), .pipe_mode(pipe_mode), .rdata(rdata1), .rdrive(rdrive1));

   task automatic apply(vec_t v);
      strb_p_n = v.p_n;  strb_c_n = v.c_n;  adv_n = v.adv_n;
      ce1_n = v.ce1_n;   ce2 = v.ce2;       ce3_n = v.ce3_n;
      gw_n = v.gw_n;     bwe_n = v.bwe_n;   lane_we_n = v.lw_n;
      oe_n = v.oe_n;     addr = v.a;        wdata = v.wd;
   endtask

   task automatic chk(int rq, logic drv, logic [35:0] d, logic edrv, logic [35:0] ed);
      checks++;
      if (drv !== edrv || d !== ed) begin
         failures++;
         $display("FAIL R%0d: actual drv=%0b data=%h expected drv=%0b data=%h",
                  rq, drv, d, edrv, ed);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      apply(mk(1,1,1,0,1,0,1,1,4'hF,0,8'h00,0,0,0,0));
      pipe_mode = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(14, rdrive, rdata, 1'b0, 36'h0);                    // R14 reset state

      foreach (TBL[i]) begin
         apply(TBL[i]);
         step();
         chk(int'(TBL[i].rq), rdrive, rdata, TBL[i].edrv, TBL[i].ed);
      end

      // R7 / R5: start at 0x11, linear vs interleaved second and third beat
      apply(mk(0,1,1,0,1,0,1,1,4'hF,0,8'h11,0,0,0,7));
      step();
      chk(1, rdrive, rdata, 1'b1, MRG);
      apply(mk(1,1,0,0,1,0,1,1,4'hF,0,8'h00,0,0,0,7));
      step();
      chk(5, rdrive, rdata, 1'b1, A3);                        // R5 linear 0x12
      chk(7, rdrive1, rdata1, 1'b1, A1);                      // R7 interleaved 0x10
      step();
      chk(7, rdrive1, rdata1, 1'b1, A4);                      // R7 interleaved 0x13

      // R13: single deselect then write, neither slot driven
      apply(mk(1,0,1,0,1,1,1,1,4'hF,0,8'h00,0,0,0,13));
      step();
      chk(13, rdrive, rdata, 1'b0, 36'h0);
      apply(mk(1,0,1,0,1,0,0,1,4'hF,0,8'h20,PV,0,0,9));
      step();
      chk(9, rdrive, rdata, 1'b0, 36'h0);                     // R9 write slot undriven

      // R10: registered path, one extra clock
      pipe_mode = 1'b1;
      apply(mk(0,1,1,0,1,0,1,1,4'hF,0,8'h20,0,0,0,10));
      step();
      chk(10, rdrive, rdata, 1'b0, 36'h0);
      apply(mk(1,1,0,0,1,0,1,1,4'hF,0,8'h00,0,0,0,10));
      step();
      chk(10, rdrive, rdata, 1'b1, PV);
      apply(mk(1,1,1,0,1,0,1,1,4'hF,0,8'h00,0,0,0,10));
      step();
      chk(10, rdrive, rdata, 1'b1, 36'h0);                    // 0x21 unwritten

      // R11: asynchronous output enable, no clock edge in between
      oe_n = 1'b1;
      #1;
      chk(11, rdrive, rdata, 1'b0, 36'h0);
      oe_n = 1'b0;
      #1;
      chk(11, rdrive, rdata, 1'b1, 36'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R14: watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule